// File: doc/BRIEF.md
# Programmable Thermal Warning Monitor

This block watches a digitised die temperature and raises a warning flag when it gets too hot. The trip temperature is set by a programming resistance. That resistance arrives as an integer number of ohms and is turned into a whole-degree trip point by a linear mapping. Once the warning is set, it stays set until the temperature has dropped a fixed ten degrees below the trip point. The flag drives the enable of an open-drain pull-down, so the pin it controls is active low. The flag is for reporting only and has no path into any gate-drive logic.

The temperature code and the resistance value are each registered once on entry. A new warning decision must then persist for a parameterised number of clock cycles before the output follows it. This filters short excursions and models a propagation delay of roughly ten microseconds. Any decision that does not last the full window is dropped, and the window starts again from zero.

Top module: `thwm_monitor`

## Requirements
- R1: The trip temperature is 70 + floor((R - 82000) / 248) degrees, where R is `rtOhms`, using integer division that rounds down. For example, 82000 gives 70, 82247 gives 70, 82248 gives 71 and 89500 gives 100.
- R2: The trip temperature is clamped to the range 70 to 130. Any R below 82000 gives 70, and any R of 96880 or more gives 130.
- R3: While the flag is clear, a temperature greater than or equal to the trip temperature sets it. `warnPullDown` = 1 means the pin is pulled low.
- R4: While the flag is set, it clears only when the temperature is less than or equal to the trip temperature minus 10. Temperatures strictly between trip-10 and the trip temperature leave the flag unchanged in either state.
- R5: When the inputs change to values that call for a new flag state and then hold, `warnPullDown` changes on the (SETTLE_CYCLES+1)-th rising clock edge after the change. That is one edge of input registration plus SETTLE_CYCLES edges of settling.
- R6: A new flag state that is called for during fewer than SETTLE_CYCLES consecutive registered samples is discarded and leaves `warnPullDown` unchanged. The settling count restarts from zero.
- R7: While `rstN` is low, `warnPullDown` is 0. After reset it stays 0 until a condition from R3 has settled as described in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tempC | input | TEMP_WIDTH (8) | Die temperature in whole degrees C, unsigned |
| rtOhms | input | RES_WIDTH (20) | Programming resistance in ohms, unsigned |
| warnPullDown | output | 1 | Enable for the open-drain pull-down; 1 = warning (pin low) |

## Verification
The bench attacks several boundaries, each of which a wrong design would fail in a visible way:

- **Conversion edges.** The bench drives 82247 and 82248 ohms. A design that rounded to nearest, or was off by one in the offset, would move the trip point by a degree.
- **Clamp limits.** The bench drives values below 82000 ohms and far above 96880 ohms. A design that did not clamp would wrap the trip point or leave it unclamped.
- **Hysteresis band.** The bench sits one degree inside and on each edge of the trip-10 to trip band. A design without hysteresis, or with the wrong comparison direction, would chatter or release early.
- **Settling window.** The bench samples one edge before and one edge after the expected change, and applies a hot pulse exactly one cycle shorter than the window. A counter with an off-by-one, or one that failed to restart, would switch early or let the glitch through.

// File: rtl/thwm_pkg.sv
package thwm_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic cntClr;   // return settle counter to zero
    logic cntInc;   // advance settle counter
    logic commit;   // flip the warning flag
  } thwmStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_SETTLE = 1'b1
  } thwmState_e;

endpackage

// File: rtl/thwm_datapath.sv
module thwm_datapath
  import thwm_pkg::*;
#(
  parameter int TEMP_WIDTH    = 8,
  parameter int RES_WIDTH     = 20,
  parameter int SETTLE_CYCLES = 1000,
  parameter int TRIP_MIN      = 70,
  parameter int TRIP_MAX      = 130,
  parameter int HYST_DEG      = 10,
  parameter int RES_BASE      = 82000,
  parameter int RES_STEP      = 248
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [TEMP_WIDTH-1:0] tempC,
  input  logic [RES_WIDTH-1:0]  rtOhms,
  input  thwmStrobe_t           strobe,
  output logic                  mismatch,
  output logic                  cntDone,
  output logic                  warnQ
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0]      CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [RES_WIDTH-1:0]  BASE_V   = RES_WIDTH'(RES_BASE);
  localparam logic [RES_WIDTH-1:0]  STEP_V   = RES_WIDTH'(RES_STEP);
  localparam logic [RES_WIDTH-1:0]  SPAN_V   = RES_WIDTH'(TRIP_MAX - TRIP_MIN);
  localparam logic [TEMP_WIDTH-1:0] MIN_V    = TEMP_WIDTH'(TRIP_MIN);
  localparam logic [TEMP_WIDTH-1:0] MAX_V    = TEMP_WIDTH'(TRIP_MAX);
  localparam logic [TEMP_WIDTH-1:0] HYST_V   = TEMP_WIDTH'(HYST_DEG);

  logic [TEMP_WIDTH-1:0] tempReg;
  logic [TEMP_WIDTH-1:0] tripReg;
  logic [TEMP_WIDTH-1:0] tripNext;
  logic [RES_WIDTH-1:0]  resDiff;
  logic [RES_WIDTH-1:0]  resQuo;
  logic [CNT_W-1:0]      cnt;
  logic                  isHot;
  logic                  isCold;
  logic                  target;

  // Resistance to trip temperature: offset, floor divide, clamp
  always_comb begin
    resDiff  = rtOhms - BASE_V;
    resQuo   = resDiff / STEP_V;
    if (rtOhms < BASE_V) begin
      tripNext = MIN_V;
    end else if (resQuo >= SPAN_V) begin
      tripNext = MAX_V;
    end else begin
      tripNext = MIN_V + TEMP_WIDTH'(resQuo);
    end
  end

  // Input registration stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempReg <= '0;
      tripReg <= MAX_V;
    end else begin
      tempReg <= tempC;
      tripReg <= tripNext;
    end
  end

  // Threshold comparison with hysteresis
  always_comb begin
    isHot    = (tempReg >= tripReg);
    isCold   = (tempReg <= (tripReg - HYST_V));
    target   = warnQ ? !isCold : isHot;
    mismatch = (target != warnQ);
  end

  // Settle counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntClr) begin
      cnt <= '0;
    end else if (strobe.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntDone = (cnt == CNT_LAST);

  // Warning flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnQ <= 1'b0;
    end else if (strobe.commit) begin
      warnQ <= ~warnQ;
    end
  end

  // R2
  trip_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tripReg >= MIN_V) && (tripReg <= MAX_V));

  // R3
  warn_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warnQ) |-> $past(tempReg >= tripReg));

  // R4
  warn_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(warnQ) |-> $past(tempReg <= (tripReg - HYST_V)));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LAST);

  // R6
  warn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(warnQ));

endmodule

// File: rtl/thwm_control.sv
module thwm_control
  import thwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mismatch,
  input  logic        cntDone,
  output thwmStrobe_t strobe
);

  thwmState_e state;
  thwmState_e stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (mismatch) begin
          if (cntDone) begin
            strobe.commit = 1'b1;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
            stateNext     = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (!mismatch) begin
          strobe.cntClr = 1'b1;
          stateNext     = ST_IDLE;
        end else if (cntDone) begin
          strobe.commit = 1'b1;
          strobe.cntClr = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  // R5
  commit_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> mismatch && cntDone);

  // R6
  drop_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE) && !mismatch |=> (state == ST_IDLE));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cntInc, strobe.commit}));

endmodule

// File: rtl/thwm_monitor.sv
module thwm_monitor
  import thwm_pkg::*;
#(
  parameter int TEMP_WIDTH    = 8,
  parameter int RES_WIDTH     = 20,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [TEMP_WIDTH-1:0] tempC,
  input  logic [RES_WIDTH-1:0]  rtOhms,
  output logic                  warnPullDown
);

  thwmStrobe_t strobe;
  logic        mismatch;
  logic        cntDone;
  logic        warnQ;

  thwm_datapath #(
    .TEMP_WIDTH    (TEMP_WIDTH),
    .RES_WIDTH     (RES_WIDTH),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tempC    (tempC),
    .rtOhms   (rtOhms),
    .strobe   (strobe),
    .mismatch (mismatch),
    .cntDone  (cntDone),
    .warnQ    (warnQ)
  );

  thwm_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .mismatch (mismatch),
    .cntDone  (cntDone),
    .strobe   (strobe)
  );

  assign warnPullDown = warnQ;

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !warnPullDown);

endmodule

// File: tb/thwm_monitor_bench.sv
module thwm_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 12;
  localparam int TW         = 8;
  localparam int RW         = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] tempC = '0;
  logic [RW-1:0] rtOhms = '0;
  logic          warnPullDown;

  int  checks = 0;
  int  fails  = 0;
  bit  expWarn = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thwm_monitor #(
    .TEMP_WIDTH    (TW),
    .RES_WIDTH     (RW),
    .SETTLE_CYCLES (SETTLE)
  ) u_thwm_monitor (
    .clk          (clk),
    .rstN         (rstN),
    .tempC        (tempC),
    .rtOhms       (rtOhms),
    .warnPullDown (warnPullDown)
  );

  function automatic int expTrip(int r);
    int q;
    if (r < 82000) return 70;
    q = (r - 82000) / 248;
    if (q > 60) q = 60;
    return 70 + q;
  endfunction

  function automatic bit nextWarn(bit cur, int t, int r);
    int trip;
    trip = expTrip(r);
    if (cur) return !(t <= trip - 10);
    return (t >= trip);
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: warnPullDown=%0b expected %0b", req, act, exp);
    end
  endtask

  // drive at a falling edge, hold long enough to settle, update model, check
  task automatic settleTo(string req, int t, int r);
    @(negedge clk);
    tempC  = TW'(t);
    rtOhms = RW'(r);
    repeat (SETTLE + 3) @(negedge clk);
    expWarn = nextWarn(expWarn, t, r);
    check(req, warnPullDown, expWarn);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    // R7: reset holds output low even with a hot input
    tempC  = 8'd200;
    rtOhms = 20'd82000;
    repeat (4) @(negedge clk);
    check("R7 in reset", warnPullDown, 1'b0);
    tempC = 8'd20;
    @(negedge clk);
    rstN = 1'b1;
    repeat (SETTLE + 3) @(negedge clk);
    check("R7 after reset", warnPullDown, 1'b0);

    // R1: tabulated points and floor rounding
    settleTo("R1 82000 t69", 69, 82000);
    settleTo("R1 82000 t70", 70, 82000);
    settleTo("R4 release", 60, 82000);
    settleTo("R1 89500 t99", 99, 89500);
    settleTo("R1 89500 t100", 100, 89500);
    settleTo("R4 band 91", 91, 89500);
    settleTo("R4 edge 90", 90, 89500);
    settleTo("R4 band 99", 99, 89500);
    settleTo("R1 82248 t70", 70, 82248);
    settleTo("R1 82247 t70", 70, 82247);
    settleTo("R4 release", 50, 82247);

    // R2: clamp limits
    settleTo("R2 low clamp", 70, 30000);
    settleTo("R4 release", 60, 30000);
    settleTo("R2 high clamp t129", 129, 500000);
    settleTo("R2 high clamp t130", 130, 500000);
    settleTo("R2 96880 t120", 120, 96880);
    settleTo("R2 96880 t119", 119, 96880);
    settleTo("R3 cold", 30, 89500);

    // R5: exact edge of the change
    @(negedge clk);
    tempC = 8'd110;
    repeat (SETTLE) @(negedge clk);
    check("R5 before edge", warnPullDown, 1'b0);
    @(negedge clk);
    check("R5 at edge", warnPullDown, 1'b1);
    expWarn = 1'b1;
    settleTo("R3 cold", 30, 89500);

    // R6: hot pulse one cycle shorter than the window
    @(negedge clk);
    tempC = 8'd120;
    repeat (SETTLE - 1) @(negedge clk);
    tempC = 8'd30;
    repeat (SETTLE + 3) @(negedge clk);
    check("R6 glitch dropped", warnPullDown, 1'b0);
    // window restarts: another short pulse still dropped
    tempC = 8'd120;
    repeat (SETTLE - 1) @(negedge clk);
    tempC = 8'd30;
    repeat (SETTLE + 3) @(negedge clk);
    check("R6 restart", warnPullDown, 1'b0);

    // R3/R4 random temperatures around random trip points
    for (int i = 0; i < 60; i++) begin
      int r;
      int t;
      r = 78000 + int'($urandom_range(0, 22000));
      t = expTrip(r) - 14 + int'($urandom_range(0, 18));
      settleTo("R3 R4 random", t, r);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule